// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block merges six level-sensitive hardware interrupt lines and two software request bits into one interrupt request toward a CPU. Each of the eight sources has a fixed priority and its own handler entry. The block picks the highest-numbered source that is enabled, allowed by the global enable and strictly above the level now being serviced. For that winner it presents a vector number, a vector address built from a base and a spacing, and the index of the shadow register set that the handler should switch to. With one register bank per priority level, handlers do not have to save and restore context.

The CPU pulses an acknowledge input to take the presented source. The block then raises its current level to that source and pushes the previous level onto an internal stack. An end-of-handler pulse pops the stack and restores the interrupted level, so nested handlers unwind in reverse order. The number of shadow register sets is a build parameter (1, 2, 4 or 8). Any mapped set index that does not exist in the build is forced to set 0.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_req_o` is 0, `cur_lvl_o` is 0 and both software request bits are 0.
- R2: Source numbers are fixed. Sources 0 and 1 are software bits 0 and 1, and sources 2 to 7 are hardware lines 0 to 5. Among eligible sources the highest number wins, and `vec_num_o` shows it while `irq_req_o` is 1.
- R3: A pending source is eligible only if its bit in `src_en_i` is 1 and `global_en_i` is 1. If no source is eligible, `irq_req_o` is 0.
- R4: `cur_lvl_o` is 0 when no handler runs and s+1 while the handler of source s runs. Source s is eligible only if s+1 is strictly greater than `cur_lvl_o`.
- R5: Hardware lines are level sensitive and pass through two synchronizing flops. A change that is set up before clock edge k shows at the request outputs after edge k+1, and not after edge k.
- R6: `sw_wr_en_i` loads `sw_wr_data_i` into the two software bits, which show after the next edge. Otherwise the bits hold, and acknowledge or end-of-handler never clears them.
- R7: `vec_addr_o` = `vec_base_i` + `vec_num_o` × 2^(5+`vec_space_i`). Spacing codes 0, 1, 2 and 3 give 32, 64, 128 and 256 bytes.
- R8: `shadow_set_o` is field `shadow_map_i[3s+2:3s]` of winner s. It is 0 whenever that field is at or above the configured set count.
- R9: `ack_i` while `irq_req_o` is 1 sets `cur_lvl_o` to winner+1 after the edge and pushes the previous level. `ack_i` while `irq_req_o` is 0 is ignored.
- R10: `eoh_i` restores the most recently pushed level after the edge. At level 0 it is ignored. If `ack_i` is taken in the same cycle, `eoh_i` is ignored.
- R11: Nesting reaches eight levels, and the levels restore in exact reverse order on successive end-of-handler pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | 6 | Asynchronous level-sensitive hardware lines |
| sw_wr_en_i | input | 1 | Write strobe for the software request bits |
| sw_wr_data_i | input | 2 | New value of the software request bits |
| global_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 8 | Per-source enable, bit s for source s |
| vec_base_i | input | 32 | Vector table base address |
| vec_space_i | input | 2 | Vector spacing code (32 << code bytes) |
| shadow_map_i | input | 24 | Eight 3-bit shadow set entries, entry s at bits 3s+2:3s |
| ack_i | input | 1 | CPU takes the presented interrupt |
| eoh_i | input | 1 | CPU leaves the current handler |
| irq_req_o | output | 1 | An eligible source is presented |
| vec_num_o | output | 3 | Winning source number |
| vec_addr_o | output | 32 | Handler address of the winner |
| shadow_set_o | output | 3 | Shadow register set for the winner |
| cur_lvl_o | output | 4 | Level now being serviced (0 = none) |

## Verification
Request, vector number, address and shadow set are combinational from registered state. They follow a change to the enables, base, spacing or map in the same cycle, a software write after one edge, and a hardware line after two edges. The current level moves one edge after an acknowledge or end-of-handler pulse. The bench drives every input 1 ns after a rising edge and samples 1 ns after the edge on which the result becomes due. For hardware lines it also samples after the first edge, to show that the change is not yet visible.

// File: rtl/irq_pkg.sv
// Package irq_pkg: shared encodings for the vectored interrupt controller.
// Assumes the spacing code is interpreted as a left shift added to 5.
package irq_pkg;
    // Vector spacing codes; byte spacing is 32 << code.
    typedef enum logic [1:0] {
        SPACE_32  = 2'd0,
        SPACE_64  = 2'd1,
        SPACE_128 = 2'd2,
        SPACE_256 = 2'd3
    } vec_space_e;

    // Width of one shadow map entry (sets 0..7).
    localparam int unsigned SET_W = 3;

    // Shift amount that turns a source number into a table offset.
    function automatic int unsigned space_shift(input logic [1:0] code);
        return 5 + int'(code);
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Module irq_sync: two-flop synchronizer for a bus of independent level
// signals. Assumes each bit is an unrelated level (no bus coherency).
module irq_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two register stages per bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/irq_prio.sv
// Module irq_prio: fixed-priority selection among NSRC sources. Source s
// competes at level s+1 and must beat the current level strictly; the
// highest eligible number wins. Assumes cur_lvl uses 0 for "no handler".
module irq_prio #(
    parameter int unsigned NSRC  = 8,
    localparam int unsigned IDX_W = $clog2(NSRC),
    localparam int unsigned LVL_W = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend_i,
    input  logic [NSRC-1:0]  en_i,
    input  logic             gen_i,
    input  logic [LVL_W-1:0] cur_lvl_i,
    output logic             any_o,
    output logic [IDX_W-1:0] win_o
);
    logic [NSRC-1:0] elig;

    // Per-source eligibility: pending, enabled, and above the current level.
    for (genvar s = 0; s < NSRC; s++) begin : g_elig
        localparam logic [LVL_W-1:0] SRC_LVL = LVL_W'(s + 1);
        assign elig[s] = pend_i[s] && en_i[s] && gen_i && (SRC_LVL > cur_lvl_i);
    end

    // Encoder: scan upward so the highest eligible number is kept.
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (elig[s]) begin
                any_o = 1'b1;
                win_o = IDX_W'(s);
            end
        end
    end

    // R3
    // winner_enabled_chk: a presented winner is always enabled, pending and globally allowed
    winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (gen_i && en_i[win_o] && pend_i[win_o]));
endmodule

// File: rtl/irq_lvl_stack.sv
// Module irq_lvl_stack: holds the current service level and a LIFO of
// interrupted levels. A push installs a new level and saves the old one;
// a pop restores the saved one. Push wins over pop. Assumes the caller
// pushes only strictly higher levels, so DEPTH pushes cannot be exceeded.
module irq_lvl_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LVL_W = 4,
    localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] cur_lvl_o
);
    logic [LVL_W-1:0] stk_q [DEPTH];
    logic [SP_W-1:0]  sp_q;
    logic [LVL_W-1:0] cur_q;
    logic             do_pop;

    assign do_pop = pop_i && !push_i && (sp_q != '0);

    // Level and stack update: push on entry, pop on handler exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            sp_q  <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (push_i) begin
            stk_q[sp_q[$clog2(DEPTH)-1:0]] <= cur_q;
            sp_q  <= sp_q + 1'b1;
            cur_q <= push_lvl_i;
        end else if (do_pop) begin
            cur_q <= stk_q[sp_q[$clog2(DEPTH)-1:0] - 1'b1];
            sp_q  <= sp_q - 1'b1;
        end
    end

    assign cur_lvl_o = cur_q;

    // R11
    // stack_no_overflow_chk: a push never happens with the stack full
    stack_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (sp_q < SP_W'(DEPTH)));

    // R10
    // pop_lowers_chk: a pop returns to a strictly lower level
    pop_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> (cur_q < $past(cur_q)));

    // R10
    // idle_level_chk: an empty stack means no handler is active
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q == '0) |-> (cur_q == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module vec_irq_ctrl: vectored, prioritized interrupt controller with a
// shadow register set per level. Sources 0..SW_BITS-1 are software bits,
// the rest are hardware lines. Assumes SHADOW_SETS is 1, 2, 4 or 8 and that
// configuration inputs are quasi-static relative to the CPU's use of them.
module vec_irq_ctrl #(
    parameter int unsigned HW_LINES    = 6,
    parameter int unsigned SW_BITS     = 2,
    parameter int unsigned SHADOW_SETS = 4,
    parameter int unsigned ADDR_W      = 32,
    localparam int unsigned NSRC  = HW_LINES + SW_BITS,
    localparam int unsigned IDX_W = $clog2(NSRC),
    localparam int unsigned LVL_W = $clog2(NSRC + 1),
    localparam int unsigned MAP_W = NSRC * irq_pkg::SET_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HW_LINES-1:0]        hw_irq_i,
    input  logic                       sw_wr_en_i,
    input  logic [SW_BITS-1:0]         sw_wr_data_i,
    input  logic                       global_en_i,
    input  logic [NSRC-1:0]            src_en_i,
    input  logic [ADDR_W-1:0]          vec_base_i,
    input  logic [1:0]                 vec_space_i,
    input  logic [MAP_W-1:0]           shadow_map_i,
    input  logic                       ack_i,
    input  logic                       eoh_i,
    output logic                       irq_req_o,
    output logic [IDX_W-1:0]           vec_num_o,
    output logic [ADDR_W-1:0]          vec_addr_o,
    output logic [irq_pkg::SET_W-1:0]  shadow_set_o,
    output logic [LVL_W-1:0]           cur_lvl_o
);
    import irq_pkg::*;

    logic [HW_LINES-1:0] hw_sync;
    logic [SW_BITS-1:0]  sw_q;
    logic [NSRC-1:0]     pend;
    logic                any;
    logic [IDX_W-1:0]    win;
    logic [LVL_W-1:0]    cur_lvl;
    logic                take;
    logic [SET_W-1:0]    map_ent;

    irq_sync #(.WIDTH(HW_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hw_irq_i),
        .sync_o  (hw_sync)
    );

    // Software request bits: written only by the register strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          sw_q <= '0;
        else if (sw_wr_en_i) sw_q <= sw_wr_data_i;
    end

    assign pend = {hw_sync, sw_q};

    irq_prio #(.NSRC(NSRC)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .en_i      (src_en_i),
        .gen_i     (global_en_i),
        .cur_lvl_i (cur_lvl),
        .any_o     (any),
        .win_o     (win)
    );

    assign take = ack_i && any;

    irq_lvl_stack #(.DEPTH(NSRC), .LVL_W(LVL_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_lvl_i (LVL_W'(win) + 1'b1),
        .pop_i      (eoh_i),
        .cur_lvl_o  (cur_lvl)
    );

    // Vector address: base plus source number scaled by the spacing.
    always_comb begin
        vec_addr_o = vec_base_i + (ADDR_W'(win) << space_shift(vec_space_i));
    end

    assign map_ent = shadow_map_i[win*SET_W +: SET_W];

    // Shadow set lookup; clamp only when fewer than 8 sets exist.
    if (SHADOW_SETS >= (1 << SET_W)) begin : g_no_clamp
        assign shadow_set_o = map_ent;
    end else begin : g_clamp
        assign shadow_set_o = (map_ent >= SET_W'(SHADOW_SETS)) ? '0 : map_ent;
    end

    assign irq_req_o = any;
    assign vec_num_o = win;
    assign cur_lvl_o = cur_lvl;

    // R4
    // above_level_chk: a presented source always outranks the current level
    above_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> ((LVL_W'(vec_num_o) + 1'b1) > cur_lvl_o));

    // R9
    // ack_enters_chk: a taken acknowledge moves to the winner's level
    ack_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o) |=> (cur_lvl_o == LVL_W'($past(vec_num_o)) + 1'b1));

    // R6
    // sw_hold_chk: software bits change only on a write strobe
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en_i |=> $stable(sw_q));

    // R8
    // shadow_range_chk: a presented shadow set always exists in this build
    shadow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (int'(shadow_set_o) < SHADOW_SETS));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
// Directed bench for vec_irq_ctrl; one task per scenario.
module vec_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  hw_irq;
    logic        sw_wr_en;
    logic [1:0]  sw_wr_data;
    logic        gen;
    logic [7:0]  src_en;
    logic [31:0] base;
    logic [1:0]  space;
    logic [23:0] smap;
    logic        ack;
    logic        eoh;
    logic        req;
    logic [2:0]  vnum;
    logic [31:0] vaddr;
    logic [2:0]  sset;
    logic [3:0]  lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq),
        .sw_wr_en_i(sw_wr_en), .sw_wr_data_i(sw_wr_data),
        .global_en_i(gen), .src_en_i(src_en), .vec_base_i(base),
        .vec_space_i(space), .shadow_map_i(smap), .ack_i(ack), .eoh_i(eoh),
        .irq_req_o(req), .vec_num_o(vnum), .vec_addr_o(vaddr),
        .shadow_set_o(sset), .cur_lvl_o(lvl)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hw_irq = '0; sw_wr_en = 1'b0; sw_wr_data = '0;
        gen = 1'b1; src_en = 8'hFF; base = 32'h0; space = 2'd0;
        smap = '0; ack = 1'b0; eoh = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic sw_write(input logic [1:0] v);
        sw_wr_en = 1'b1; sw_wr_data = v;
        step(1);
        sw_wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic pulse_eoh();
        eoh = 1'b1; step(1); eoh = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req", req, 0);
        chk("R1 lvl", lvl, 0);
        step(3);
        chk("R1 sw bits clear (no req)", req, 0);
    endtask

    task automatic t_sw();
        do_reset();
        sw_write(2'b01);
        chk("R6 sw0 req", req, 1);
        chk("R2 sw0 num", vnum, 0);
        sw_write(2'b11);
        chk("R2 sw1 wins", vnum, 1);
        step(4);
        chk("R6 sw held", {req, vnum}, {1'b1, 3'd1});
        pulse_ack();
        chk("R6 ack leaves sw pending src0 blocked", req, 0);
        pulse_eoh();
        chk("R6 bits survive ack/eoh", {req, vnum}, {1'b1, 3'd1});
        sw_write(2'b00);
        chk("R6 sw cleared", req, 0);
    endtask

    task automatic t_hw_sync();
        do_reset();
        sw_write(2'b11);
        hw_irq[5] = 1'b1;
        step(1);
        chk("R5 not after first edge", vnum, 1);
        step(1);
        chk("R5 visible after second edge", vnum, 7);
        chk("R2 hw5 is source 7", req, 1);
        hw_irq[5] = 1'b0;
        step(2);
        chk("R5 level drop", vnum, 1);
    endtask

    task automatic t_mask();
        do_reset();
        sw_write(2'b10);
        hw_irq = 6'b100001;
        step(2);
        chk("R2 top wins", vnum, 7);
        src_en = 8'h7F; #1;
        chk("R3 mask src7", vnum, 2);
        src_en = 8'h7B; #1;
        chk("R3 mask src2", vnum, 1);
        gen = 1'b0; #1;
        chk("R3 global off", req, 0);
        gen = 1'b1; src_en = 8'h00; #1;
        chk("R3 all masked", req, 0);
    endtask

    task automatic t_vec();
        do_reset();
        hw_irq[5] = 1'b1; base = 32'h1000;
        step(2);
        for (int c = 0; c < 4; c++) begin
            space = 2'(c); #1;
            chk("R7 vector address", vaddr, 32'h1000 + (32'd7 << (5 + c)));
        end
        hw_irq = 6'b000001; sw_write(2'b00);
        step(2);
        space = 2'd3; #1;
        chk("R7 source 2 spacing 256", vaddr, 32'h1200);
    endtask

    task automatic t_shadow();
        do_reset();
        hw_irq[5] = 1'b1;
        step(2);
        smap = 24'd3 << 21; #1;
        chk("R8 entry 7 = 3", sset, 3);
        smap = 24'd5 << 21; #1;
        chk("R8 clamp 5 -> 0", sset, 0);
        smap = 24'd4 << 21; #1;
        chk("R8 clamp 4 -> 0", sset, 0);
        hw_irq = 6'b000100; smap = 24'd2 << 12;
        step(2);
        chk("R8 entry 4 = 2", sset, 2);
    endtask

    task automatic t_preempt();
        do_reset();
        hw_irq[0] = 1'b1;
        step(2);
        chk("R2 hw0 is source 2", vnum, 2);
        pulse_ack();
        chk("R9 level after ack", lvl, 3);
        chk("R4 same source blocked", req, 0);
        sw_write(2'b11);
        chk("R4 lower sources blocked", req, 0);
        hw_irq[3] = 1'b1;
        step(2);
        chk("R4 higher preempts", {req, vnum}, {1'b1, 3'd5});
        pulse_ack();
        chk("R9 nested level", lvl, 6);
        pulse_ack();
        chk("R9 ack without req ignored", lvl, 6);
        pulse_eoh();
        chk("R10 restore", lvl, 3);
        pulse_eoh();
        chk("R10 restore idle", lvl, 0);
        pulse_eoh();
        chk("R10 eoh at idle ignored", lvl, 0);
        ack = 1'b1; eoh = 1'b1; step(1); ack = 1'b0; eoh = 1'b0;
        chk("R10 ack beats eoh", lvl, 6);
    endtask

    task automatic t_deep();
        do_reset();
        sw_write(2'b01); pulse_ack();
        sw_write(2'b11); pulse_ack();
        for (int k = 0; k < 6; k++) begin
            hw_irq[k] = 1'b1;
            step(2);
            pulse_ack();
        end
        chk("R11 depth 8", lvl, 8);
        chk("R4 nothing above 8", req, 0);
        for (int k = 7; k >= 0; k--) begin
            pulse_eoh();
            chk("R11 unwind", lvl, 32'(k));
        end
    endtask

    initial begin
        t_reset();
        t_sw();
        t_hw_sync();
        t_mask();
        t_vec();
        t_shadow();
        t_preempt();
        t_deep();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule